// File: doc/BRIEF.md
# Dual-output interrupt aggregator

This block gathers end-of-work events from sixteen channels into one shared pending vector. It presents that vector to two interrupt lines. Each line has its own enable mask, its own register for forcing interrupts, and its own masked status view. Software reaches everything through a small register port: a write strobe, an address, write data and combinational read data.

A channel raises its pending bit when its completion pulse arrives, unless the channel is in quiet mode. A trigger with a zero transfer count raises the bit whether the channel is quiet or not. Software acknowledges pending bits by writing ones to them. A forced bit behaves like a pending bit, but only for its own output. It stays set until software writes it back to zero.

Top module: `irq_combiner`

## Requirements
- R1: A `done_pulse` bit whose `quiet` bit is 0 sets the matching bit of the pending vector. The pending vector reads back at address 0, and the new value is visible after the next rising clock edge.
- R2: Writing address 0 clears every pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R3: If an event and a clearing write reach the same pending bit in the same cycle, the bit is set afterwards.
- R4: Address 1 holds the enable mask of output 0, and address 4 holds the enable mask of output 1. Each mask is written and read back in full.
- R5: Address 2 holds the force mask of output 0, and address 5 holds the force mask of output 1. A forced bit stays set until that address is written with a 0 in that bit.
- R6: Address 3 reads the status of output 0 and address 6 reads the status of output 1. The status of output k is (pending OR force_k) AND enable_k. Writes to addresses 3, 6 and 7 change no state.
- R7: `irq[k]` is high exactly when the status of output k is non-zero. It follows register state with no added delay.
- R8: A `done_pulse` bit whose `quiet` bit is 1 leaves the pending vector unchanged.
- R9: A `zero_trig` bit sets the matching pending bit whatever the value of `quiet`.
- R10: While `rst_n` is low, all pending, enable and force bits are cleared. Address 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_pulse | input | 16 | Single-cycle per-channel completion pulses |
| zero_trig | input | 16 | Single-cycle per-channel zero-count trigger pulses |
| quiet | input | 16 | Per-channel quiet-mode flags |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 2 | Interrupt lines, one per output |

## Verification
Two functions can land on the same pending bit in one cycle: a channel event setting it, and a software acknowledge clearing it. The bench provokes this directly by pulsing channel 9 while it writes a one to that bit at address 0, and it expects the bit to read back set. A long random phase then produces many more such overlaps, mixing quiet flags, forced bits and writes. A behavioural per-channel model judges every cycle of that phase on both IRQ lines and the read data.

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int NCH = 16,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] done_pulse,
  input  logic [NCH-1:0] zero_trig,
  input  logic [NCH-1:0] quiet,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [NCH-1:0] reg_wdata,
  output logic [NCH-1:0] reg_rdata,
  output logic [1:0]     irq
);
  localparam int NOUT = 2;
  localparam logic [AW-1:0] A_PEND = AW'(0);

  logic [NCH-1:0] pend;
  logic [NCH-1:0] ev;
  logic [NCH-1:0] clr;
  logic [NCH-1:0] en  [NOUT];
  logic [NCH-1:0] frc [NOUT];
  logic [NCH-1:0] st  [NOUT];

  assign ev  = (done_pulse & ~quiet) | zero_trig;
  assign clr = (reg_we && reg_addr == A_PEND) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | ev;
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    localparam logic [AW-1:0] A_EN  = AW'(1 + 3 * k);
    localparam logic [AW-1:0] A_FRC = AW'(2 + 3 * k);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[k]  <= '0;
        frc[k] <= '0;
      end else if (reg_we) begin
        if (reg_addr == A_EN)  en[k]  <= reg_wdata;
        if (reg_addr == A_FRC) frc[k] <= reg_wdata;
      end
    end

    assign st[k]  = (pend | frc[k]) & en[k];
    assign irq[k] = |st[k];

    // R5
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == A_FRC) |=> $stable(frc[k]));
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_PEND) reg_rdata = pend;
    for (int k = 0; k < NOUT; k++) begin
      if (reg_addr == AW'(1 + 3 * k)) reg_rdata = en[k];
      if (reg_addr == AW'(2 + 3 * k)) reg_rdata = frc[k];
      if (reg_addr == AW'(3 + 3 * k)) reg_rdata = st[k];
    end
  end

  // R3
  ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((pend & $past(ev)) == $past(ev)));

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~ev)) |=> ((pend & $past(clr & ~ev)) == '0));

  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done_pulse & quiet & ~zero_trig & ~pend)) |=>
      ((pend & $past(done_pulse & quiet & ~zero_trig & ~pend)) == '0));
endmodule

// File: tb/tb_irq_combiner.sv
module tb_irq_combiner;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] done_pulse = '0, zero_trig = '0, quiet = '0, reg_wdata = '0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  irq;

  int errors = 0, checks = 0;
  bit [15:0] m_pend, m_en0, m_en1, m_f0, m_f1;

  irq_combiner dut (.clk, .rst_n, .done_pulse, .zero_trig, .quiet,
                    .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_en0 = 0; m_en1 = 0; m_f0 = 0; m_f1 = 0;
    end else begin
      for (int i = 0; i < 16; i++) begin
        bit hit;
        hit = (done_pulse[i] && !quiet[i]) || zero_trig[i];
        if (reg_we && reg_addr == 0 && reg_wdata[i]) m_pend[i] = 0;
        if (hit) m_pend[i] = 1;
      end
      if (reg_we) begin
        if (reg_addr == 1) m_en0 = reg_wdata;
        if (reg_addr == 2) m_f0  = reg_wdata;
        if (reg_addr == 4) m_en1 = reg_wdata;
        if (reg_addr == 5) m_f1  = reg_wdata;
      end
    end
  end

  function automatic bit [15:0] m_read(input int a);
    case (a)
      0: return m_pend;
      1: return m_en0;
      2: return m_f0;
      3: return (m_pend | m_f0) & m_en0;
      4: return m_en1;
      5: return m_f1;
      6: return (m_pend | m_f1) & m_en1;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0: return "R1";
      1, 4: return "R4";
      2, 5: return "R5";
      3, 6: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      chk("R7 irq0", {15'b0, irq[0]}, {15'b0, |((m_pend | m_f0) & m_en0)});
      chk("R7 irq1", {15'b0, irq[1]}, {15'b0, |((m_pend | m_f1) & m_en1)});
      chk(tag_of(reg_addr), reg_rdata, m_read(reg_addr));
    end
  endtask

  task automatic rd(input int a, input logic [15:0] exp, input string tag);
    reg_addr = 3'(a);
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
    cyc();
    reg_we = 0; reg_wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 8; a++) rd(a, 16'h0, "R10 reset");
    chk("R10 irq reset", {14'b0, irq}, 16'h0);

    wr(1, 16'h00F0); wr(4, 16'h0F00);
    rd(1, 16'h00F0, "R4 en0"); rd(4, 16'h0F00, "R4 en1");

    done_pulse = 16'h0020; cyc(); done_pulse = '0;
    rd(0, 16'h0020, "R1 pend");
    rd(3, 16'h0020, "R6 st0");
    chk("R7 irq", {14'b0, irq}, 16'h0001);

    wr(0, 16'h0000); rd(0, 16'h0020, "R2 zero write");
    wr(0, 16'h0020); rd(0, 16'h0000, "R2 cleared");
    chk("R7 irq low", {14'b0, irq}, 16'h0000);

    quiet = 16'h0008; done_pulse = 16'h0008; cyc(); done_pulse = '0;
    rd(0, 16'h0000, "R8 quiet");
    zero_trig = 16'h0008; cyc(); zero_trig = '0; quiet = '0;
    rd(0, 16'h0008, "R9 zero trig quiet");
    wr(0, 16'hFFFF);

    reg_we = 1; reg_addr = 0; reg_wdata = 16'h0200; done_pulse = 16'h0200;
    cyc();
    reg_we = 0; reg_wdata = '0; done_pulse = '0;
    rd(0, 16'h0200, "R3 collision");
    wr(0, 16'h0200);

    wr(5, 16'h0100);
    rd(6, 16'h0100, "R6 st1 forced");
    chk("R5 irq1 forced", {14'b0, irq}, 16'h0002);
    repeat (5) cyc();
    rd(5, 16'h0100, "R5 force held");
    wr(6, 16'hFFFF); wr(3, 16'hFFFF); wr(7, 16'hFFFF);
    rd(6, 16'h0100, "R6 status write ignored");
    rd(7, 16'h0000, "R10 addr7");
    rd(1, 16'h00F0, "R6 en0 untouched");
    wr(5, 16'h0000);
    rd(6, 16'h0000, "R5 force cleared");

    for (int n = 0; n < 4000; n++) begin
      done_pulse = ($urandom % 4 == 0) ? 16'($urandom) & 16'($urandom) : '0;
      zero_trig  = ($urandom % 8 == 0) ? 16'(1 << ($urandom % 16)) : '0;
      if (n % 200 == 0) quiet = 16'($urandom);
      reg_addr = 3'($urandom);
      reg_we = ($urandom % 3 == 0);
      reg_wdata = 16'($urandom);
      cyc();
    end
    reg_we = 0; done_pulse = '0; zero_trig = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule